// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the processor state update at the moment an exception, trap or interrupt is accepted. The pipeline presents a vector of pending cause requests together with the current program counter, which has already been advanced by one word. It also presents the live status register, general register 31 and the handler vector register. In the cycle a request is present the block raises a taken strobe, which tells the pipeline to squash the faulting instruction. In that same cycle it drives the redirect target and the modified status word. On the closing clock edge it captures the save frame: the cause, the faulting address, the prior status and a copy of register 31.

The copy of register 31 sits in a dedicated shadow register. A handler can then overwrite register 31 and use it to switch to the system stack, and the user value is not lost. If several requests arrive in one cycle, the lowest-numbered one wins. Everything happens in one cycle, with no internal state beyond the frame registers.

Top module: `exc_entry_seq`

## Requirements
- R1: `exc_taken` is high in exactly those cycles in which at least one bit of `exc_req` is high, combinationally in the same cycle.
- R2: On a taken edge `cause_q` is loaded with the index of the lowest-numbered set bit of `exc_req` (bit 0 has the highest priority).
- R3: On a taken edge `epc_q` is loaded with `cur_pc - 4`, wrapping modulo 2^32 (a PC of 0 gives 0xFFFFFFFC).
- R4: On a taken edge `saved_status_q` is loaded with `status_in` exactly as presented, before the system-mode and interrupt-enable changes.
- R5: On a taken edge `saved_r31_q` is loaded with `gpr31`.
- R6: `pc_target` equals `ivec` while `exc_taken` is high and is 0 otherwise.
- R7: While taken, `status_wr_data` equals `status_in` with bit 1 (system mode) forced to 1 and bit 0 (interrupt enable) forced to 0, with all other bits unchanged. While not taken it equals `status_in` unchanged.
- R8: In a cycle with no request, `cause_q`, `epc_q`, `saved_status_q` and `saved_r31_q` keep their values.
- R9: While `rst_n` is low, all four frame registers read 0, and they clear as soon as `rst_n` falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | NCAUSE (8) | Pending cause requests, bit index is the cause code |
| cur_pc | input | 32 | Program counter, already advanced one word |
| status_in | input | 32 | Current status register |
| gpr31 | input | 32 | Current value of general register 31 |
| ivec | input | 32 | Handler vector register |
| exc_taken | output | 1 | Exception accepted this cycle; squash and redirect |
| pc_target | output | 32 | Next PC when taken, else 0 |
| status_wr_data | output | 32 | Status value to write back this cycle |
| cause_q | output | 5 | Saved cause code |
| epc_q | output | 32 | Saved faulting address |
| saved_status_q | output | 32 | Saved status word |
| saved_r31_q | output | 32 | Shadow copy of register 31 |

## Verification
The redirect, the status rewrite and the taken strobe are combinational. An arbitration or masking error therefore shows at the ports in the very cycle the requests are applied. A wrong frame capture shows one edge later on the four saved outputs. A frame register that moves without a request, or that loads the wrong priority winner, stays visible until the next accepted exception. The bench therefore checks both the same-cycle outputs and the post-edge frame for every stimulus, including idle cycles.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CAUSE_W = 5;

  typedef logic [XLEN-1:0]    word_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  typedef struct packed {
    cause_t cause;
    word_t  epc;
    word_t  status;
    word_t  r31;
  } frame_t;
endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_seq_pkg::*;
#(
  parameter int unsigned NCAUSE = 8
) (
  input  logic [NCAUSE-1:0] req,
  output logic              any,
  output cause_t            idx
);
  logic [NCAUSE:0]   lower_seen;
  logic [NCAUSE-1:0] grant;

  assign lower_seen[0] = 1'b0;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_chain
    assign grant[g]        = req[g] & ~lower_seen[g];
    assign lower_seen[g+1] = lower_seen[g] | req[g];
  end

  assign any = lower_seen[NCAUSE];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCAUSE; i++) begin
      if (grant[i]) idx = idx | cause_t'(i);
    end
  end
endmodule

// File: rtl/exc_status_mod.sv
module exc_status_mod
  import exc_seq_pkg::*;
#(
  parameter int unsigned SYS_BIT = 1,
  parameter int unsigned IE_BIT  = 0
) (
  input  logic  take,
  input  word_t cur,
  output word_t nxt
);
  always_comb begin
    nxt = cur;
    if (take) begin
      nxt[SYS_BIT] = 1'b1;
      nxt[IE_BIT]  = 1'b0;
    end
  end
endmodule

// File: rtl/exc_frame_regs.sv
module exc_frame_regs
  import exc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t d,
  output frame_t q
);
  frame_t frame_r;
  frame_t frame_nxt;

  always_comb begin
    frame_nxt = frame_r;
    if (load) frame_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_r <= '0;
    else        frame_r <= frame_nxt;
  end

  assign q = frame_r;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned NCAUSE     = 8,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned SYS_BIT    = 1,
  parameter int unsigned IE_BIT     = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCAUSE-1:0]    exc_req,
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [XLEN-1:0]      status_in,
  input  logic [XLEN-1:0]      gpr31,
  input  logic [XLEN-1:0]      ivec,
  output logic                 exc_taken,
  output logic [XLEN-1:0]      pc_target,
  output logic [XLEN-1:0]      status_wr_data,
  output logic [CAUSE_W-1:0]   cause_q,
  output logic [XLEN-1:0]      epc_q,
  output logic [XLEN-1:0]      saved_status_q,
  output logic [XLEN-1:0]      saved_r31_q
);
  localparam word_t PC_STEP = word_t'(WORD_BYTES);

  cause_t win_idx;
  logic   take;
  frame_t frame_d;
  frame_t frame_q;

  exc_prio_arb #(.NCAUSE(NCAUSE)) u_arb (
    .req (exc_req),
    .any (take),
    .idx (win_idx)
  );

  exc_status_mod #(.SYS_BIT(SYS_BIT), .IE_BIT(IE_BIT)) u_stat (
    .take (take),
    .cur  (status_in),
    .nxt  (status_wr_data)
  );

  always_comb begin
    frame_d.cause  = win_idx;
    frame_d.epc    = cur_pc - PC_STEP;
    frame_d.status = status_in;
    frame_d.r31    = gpr31;
  end

  exc_frame_regs u_frame (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take),
    .d     (frame_d),
    .q     (frame_q)
  );

  assign exc_taken      = take;
  assign pc_target      = take ? ivec : '0;
  assign cause_q        = frame_q.cause;
  assign epc_q          = frame_q.epc;
  assign saved_status_q = frame_q.status;
  assign saved_r31_q    = frame_q.r31;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_seq_pkg::*;
#(
  parameter int unsigned NCAUSE     = 8,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned SYS_BIT    = 1,
  parameter int unsigned IE_BIT     = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCAUSE-1:0]  exc_req,
  input logic [XLEN-1:0]    cur_pc,
  input logic [XLEN-1:0]    status_in,
  input logic [XLEN-1:0]    gpr31,
  input logic [XLEN-1:0]    ivec,
  input logic               exc_taken,
  input logic [XLEN-1:0]    pc_target,
  input logic [XLEN-1:0]    status_wr_data,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [XLEN-1:0]    epc_q,
  input logic [XLEN-1:0]    saved_status_q,
  input logic [XLEN-1:0]    saved_r31_q
);
  logic [NCAUSE-1:0] req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= '0;
    else        req_d <= exc_req;
  end

  AST_TAKEN_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req != '0) == exc_taken); // R1

  AST_LOWEST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> req_d[cause_q] &&
                  ((req_d & ((NCAUSE'(1) << cause_q) - NCAUSE'(1))) == '0)); // R2

  AST_EPC_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> epc_q == $past(cur_pc) - XLEN'(WORD_BYTES)); // R3

  AST_STATUS_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> saved_status_q == $past(status_in)); // R4

  AST_R31_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> saved_r31_q == $past(gpr31)); // R5

  AST_VECTOR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> pc_target == ivec); // R6

  AST_TARGET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |-> pc_target == '0); // R6

  AST_STATUS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> status_wr_data[SYS_BIT] && !status_wr_data[IE_BIT]); // R7

  AST_STATUS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |-> status_wr_data == status_in); // R7

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_taken |=> $stable(cause_q) && $stable(epc_q) &&
                   $stable(saved_status_q) && $stable(saved_r31_q)); // R8
endmodule

bind exc_entry_seq exc_entry_chk #(
  .NCAUSE(NCAUSE), .WORD_BYTES(WORD_BYTES), .SYS_BIT(SYS_BIT), .IE_BIT(IE_BIT)
) u_chk (.*);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int VW = 8 + 32*4;

  // entry: {req, pc, status, r31, ivec}
  localparam logic [VW-1:0] TBL [0:NV-1] = '{
    {8'h01, 32'h0000_1004, 32'h0000_0001, 32'hAAAA_5555, 32'h0000_0080},
    {8'h80, 32'h0000_2000, 32'h0000_0000, 32'h0000_0001, 32'h0000_0100},
    {8'hFF, 32'h0000_0000, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0200},
    {8'h0C, 32'h1234_5678, 32'hF000_0001, 32'h0000_0000, 32'h0000_0000},
    {8'h40, 32'h0000_0004, 32'h0000_0002, 32'hDEAD_BEEF, 32'h0000_0300},
    {8'hA0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0031, 32'h0000_0400},
    {8'h00, 32'h1111_0000, 32'h0000_0001, 32'h0000_0077, 32'h0000_0500},
    {8'h10, 32'hFFFF_FFFC, 32'h0000_0001, 32'h0000_0012, 32'h0000_0600}
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  exc_req;
  logic [31:0] cur_pc, status_in, gpr31, ivec;
  logic        exc_taken;
  logic [31:0] pc_target, status_wr_data;
  logic [4:0]  cause_q;
  logic [31:0] epc_q, saved_status_q, saved_r31_q;

  int n_chk;
  int n_bad;
  bit done;

  logic [31:0] e_cause, e_epc, e_st, e_r31;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_pc(cur_pc),
    .status_in(status_in), .gpr31(gpr31), .ivec(ivec),
    .exc_taken(exc_taken), .pc_target(pc_target),
    .status_wr_data(status_wr_data), .cause_q(cause_q), .epc_q(epc_q),
    .saved_status_q(saved_status_q), .saved_r31_q(saved_r31_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_frame(input string tag);
    chk({tag, " R2 cause"},   {27'd0, cause_q}, e_cause);
    chk({tag, " R3 epc"},     epc_q,            e_epc);
    chk({tag, " R4 status"},  saved_status_q,   e_st);
    chk({tag, " R5 r31"},     saved_r31_q,      e_r31);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; exc_req = '0; cur_pc = '0; status_in = '0; gpr31 = '0; ivec = '0;
    e_cause = '0; e_epc = '0; e_st = '0; e_r31 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_frame("reset R9");
    chk("reset R1 taken", {31'd0, exc_taken}, 32'd0);
    chk("reset R6 target", pc_target, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  rq;
      logic [31:0] pc, st, r31, iv, xs, lo;
      {rq, pc, st, r31, iv} = TBL[i];
      @(negedge clk);
      exc_req = rq; cur_pc = pc; status_in = st; gpr31 = r31; ivec = iv;
      #1;
      lo = 32'd0;
      for (int b = 7; b >= 0; b--) if (rq[b]) lo = 32'(b);
      xs = (rq != 0) ? ((st | 32'h2) & ~32'h1) : st;
      chk($sformatf("vec%0d R1 taken", i), {31'd0, exc_taken}, {31'd0, rq != 0});
      chk($sformatf("vec%0d R6 target", i), pc_target, (rq != 0) ? iv : 32'd0);
      chk($sformatf("vec%0d R7 status_wr", i), status_wr_data, xs);
      if (rq != 0) begin
        e_cause = lo; e_epc = pc - 32'd4; e_st = st; e_r31 = r31;
      end
      @(posedge clk);
      #1;
      chk_frame($sformatf("vec%0d R8", i));
    end

    // idle cycles: frame must hold (R8)
    @(negedge clk);
    exc_req = '0; cur_pc = 32'h5555_0000; gpr31 = 32'h0BAD_0BAD; status_in = 32'h8;
    repeat (2) @(posedge clk);
    #1;
    chk_frame("idle R8");
    chk("idle R7 passthrough", status_wr_data, 32'h8);

    // asynchronous reset mid-cycle clears frame (R9)
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    e_cause = '0; e_epc = '0; e_st = '0; e_r31 = '0;
    chk_frame("async R9");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule